// File: doc/BRIEF.md
# Sleep-Mode Wake Event Detector

This block watches two sources while a bus transceiver is asleep: a local wake pin wired to an external switch, and the level seen by the bus receiver. When either source shows a qualified wake condition, the block emits one single-cycle wake pulse to the mode controller. The pulse comes with a flag that names the source.

The wake pin has no fixed active polarity. In the cycle the sleep flag rises, the synchronised pin level is latched as the reference. Only the pin holding the opposite level counts as a wake, so a switch that opens and a switch that closes can both wake the node. A bus wake is the received level being dominant (low) while asleep.

Each source has its own filter length in clock cycles, supplied on an input port. A condition must hold for that many consecutive cycles before it is accepted. Both raw inputs pass through two-flop synchronisers first. After a pulse the detector stays quiet until the next sleep entry, which re-arms it and latches a new reference.

Top module: `sleep_wake_detect`

## Requirements
- R1: While `sleep_i` is low, no wake pulse is produced, whatever the pin and bus levels do.
- R2: If the pin is high at sleep entry, the pin going low and staying low wakes the block with `wake_src_o` = 1 (pin).
- R3: If the pin is low at sleep entry, the pin going high and staying high wakes the block with `wake_src_o` = 1.
- R4: A pin departure lasting `pin_len_i` clock cycles produces the pulse exactly `pin_len_i`+2 rising edges after the raw input changes. A departure lasting `pin_len_i`-1 cycles produces no pulse.
- R5: A dominant bus level (`bus_rx_i` = 0) lasting `bus_len_i` cycles during sleep wakes the block `bus_len_i`+2 rising edges after the change, with `wake_src_o` = 0 (bus).
- R6: A dominant bus level lasting `bus_len_i`-1 cycles produces no pulse.
- R7: The wake pulse is high for exactly one cycle. After it, no further pulse occurs until `sleep_i` falls and rises again, which re-arms the detector.
- R8: If the bus and the pin qualify in the same cycle, one pulse is produced with `wake_src_o` = 0.
- R9: Each filter count restarts from zero when its condition drops. Two short departures separated by a gap do not add up to a wake.
- R10: After reset, `wake_pulse_o` and `wake_src_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | High while the interface is in sleep (synchronous) |
| wake_pin_i | input | 1 | Raw local wake pin level (asynchronous) |
| bus_rx_i | input | 1 | Raw bus receiver level, 0 = dominant (asynchronous) |
| pin_len_i | input | CNT_W | Pin filter length in cycles |
| bus_len_i | input | CNT_W | Bus filter length in cycles |
| wake_pulse_o | output | 1 | Single-cycle wake event |
| wake_src_o | output | 1 | Source of the last wake: 0 = bus, 1 = pin |

## Verification
The hardest case to reach is both filters reaching their length in the same cycle, because the two sources take separate routes through their synchronisers and counters. The bench reaches it by changing the pin and the bus on the same falling edge, with equal filter lengths, so both counters run in lockstep. The timing boundaries are checked by holding a raw input for exactly the filter length and for one cycle less. The delay from the raw change to the pulse is counted in rising edges.

// File: rtl/sleep_wake_pkg.sv
// Package: shared types for the sleep wake detector.
// Assumes nothing beyond a standard SystemVerilog compile.
package sleep_wake_pkg;
    typedef enum logic {
        SRC_BUS = 1'b0,
        SRC_PIN = 1'b1
    } wake_src_e;

    localparam logic BUS_RECESSIVE = 1'b1;
endpackage

// File: rtl/swd_sync2.sv
// Two-flop synchroniser for one asynchronous level.
// Assumes the input is a slow level; reset forces both stages to RST_VAL.
module swd_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic stage1_q;
    logic stage2_q;

    // Shift the raw level through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/swd_filter.sv
// Persistence filter: hit_o is high in the cycle in which cond_i has been
// high for len_i consecutive cycles (including that cycle). The counter
// saturates and returns to zero whenever cond_i drops.
// A len_i of zero behaves as one.
module swd_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   run_len;

    // Length of the current run, counting this cycle.
    assign run_len = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign hit_o   = cond_i && (run_len >= {1'b0, len_i});

    // Count consecutive qualifying cycles, saturating, clearing on a drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!cond_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_i |=> (cnt_q == '0)); // R9

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R9
endmodule

// File: rtl/sleep_wake_detect.sv
// Sleep-mode wake event detector (top).
// Latches the pin level at sleep entry as a reference. It then filters a
// departure from that reference and, separately, a dominant bus level.
// It emits one pulse per sleep period. Assumes sleep_i is synchronous to
// clk, and that the raw pin and bus levels are asynchronous.
module sleep_wake_detect
    import sleep_wake_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             wake_pin_i,
    input  logic             bus_rx_i,
    input  logic [CNT_W-1:0] pin_len_i,
    input  logic [CNT_W-1:0] bus_len_i,
    output logic             wake_pulse_o,
    output logic             wake_src_o
);
    logic      pin_s;
    logic      bus_s;
    logic      sleep_q;
    logic      armed_q;
    logic      ref_q;
    logic      pin_cond;
    logic      bus_cond;
    logic      pin_hit;
    logic      bus_hit;
    logic      entry;
    logic      fire;
    logic      pulse_q;
    wake_src_e src_q;

    swd_sync2 #(.RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_i(wake_pin_i), .sync_o(pin_s)
    );

    swd_sync2 #(.RST_VAL(BUS_RECESSIVE)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .async_i(bus_rx_i), .sync_o(bus_s)
    );

    assign entry    = sleep_i && !sleep_q;
    assign pin_cond = armed_q && sleep_i && (pin_s != ref_q);
    assign bus_cond = armed_q && sleep_i && (bus_s != BUS_RECESSIVE);

    swd_filter #(.CNT_W(CNT_W)) u_pin_filt (
        .clk(clk), .rst_n(rst_n), .cond_i(pin_cond), .len_i(pin_len_i), .hit_o(pin_hit)
    );

    swd_filter #(.CNT_W(CNT_W)) u_bus_filt (
        .clk(clk), .rst_n(rst_n), .cond_i(bus_cond), .len_i(bus_len_i), .hit_o(bus_hit)
    );

    assign fire = pin_hit || bus_hit;

    // Track sleep; on entry latch the reference and arm; disarm on wake or exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
            armed_q <= 1'b0;
            ref_q   <= 1'b0;
        end else begin
            sleep_q <= sleep_i;
            if (entry) begin
                ref_q   <= pin_s;
                armed_q <= 1'b1;
            end else if (!sleep_i || fire) begin
                armed_q <= 1'b0;
            end
        end
    end

    // Register the wake pulse and its source; the bus takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            src_q   <= SRC_BUS;
        end else begin
            pulse_q <= fire;
            if (fire) begin
                src_q <= bus_hit ? SRC_BUS : SRC_PIN;
            end
        end
    end

    assign wake_pulse_o = pulse_q;
    assign wake_src_o   = src_q;

    AST_PULSE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |-> $past(sleep_i)); // R1

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |=> !wake_pulse_o); // R7

    AST_BUS_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hit && pin_hit) |=> (wake_pulse_o && wake_src_o == 1'b0)); // R8

    AST_DISARM_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse_o && !entry) |-> !pin_cond && !bus_cond); // R7
endmodule

// File: tb/sleep_wake_detect_tb_top.sv
module sleep_wake_detect_tb_top;
    localparam int CNT_W   = 8;
    localparam int PIN_LEN = 10;
    localparam int BUS_LEN = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_i = 1'b0;
    logic             wake_pin_i = 1'b0;
    logic             bus_rx_i = 1'b1;
    logic [CNT_W-1:0] pin_len_i = CNT_W'(PIN_LEN);
    logic [CNT_W-1:0] bus_len_i = CNT_W'(BUS_LEN);
    logic             wake_pulse_o;
    logic             wake_src_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pulse_cnt = 0;
    int pulse_cyc = 0;
    logic pulse_src = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sleep_wake_detect #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .wake_pin_i(wake_pin_i),
        .bus_rx_i(bus_rx_i), .pin_len_i(pin_len_i), .bus_len_i(bus_len_i),
        .wake_pulse_o(wake_pulse_o), .wake_src_o(wake_src_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Record pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wake_pulse_o) begin
            pulse_cnt <= pulse_cnt + 1;
            pulse_cyc <= cyc;
            pulse_src <= wake_src_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic enter_sleep(input logic lvl);
        wake_pin_i = lvl;
        bus_rx_i   = 1'b1;
        idle(4);
        sleep_i = 1'b1;
        idle(3);
        pulse_cnt = 0;
    endtask

    task automatic leave_sleep();
        sleep_i = 1'b0;
        idle(3);
    endtask

    task automatic t_reset();
        check(wake_pulse_o == 1'b0, "R10 pulse", wake_pulse_o, 0);
        check(wake_src_o == 1'b0, "R10 src", wake_src_o, 0);
    endtask

    task automatic t_awake_quiet();
        pulse_cnt = 0;
        wake_pin_i = ~wake_pin_i;
        bus_rx_i = 1'b0;
        idle(40);
        bus_rx_i = 1'b1;
        wake_pin_i = ~wake_pin_i;
        idle(40);
        check(pulse_cnt == 0, "R1 no wake while awake", pulse_cnt, 0);
    endtask

    task automatic t_pin_wake(input logic ref_lvl, input string req);
        int start;
        enter_sleep(ref_lvl);
        wake_pin_i = ~ref_lvl;
        start = cyc;
        idle(PIN_LEN + 6);
        check(pulse_cnt == 1, req, pulse_cnt, 1);
        check(pulse_src == 1'b1, req, pulse_src, 1);
        check(pulse_cyc - start == PIN_LEN + 2, "R4 pin latency", pulse_cyc - start, PIN_LEN + 2);
        leave_sleep();
    endtask

    task automatic t_pin_short();
        enter_sleep(1'b0);
        wake_pin_i = 1'b1;
        idle(PIN_LEN - 1);
        wake_pin_i = 1'b0;
        idle(PIN_LEN + 6);
        check(pulse_cnt == 0, "R4 short pin ignored", pulse_cnt, 0);
        leave_sleep();
    endtask

    task automatic t_bus_wake();
        int start;
        enter_sleep(1'b0);
        bus_rx_i = 1'b0;
        start = cyc;
        idle(BUS_LEN + 6);
        bus_rx_i = 1'b1;
        check(pulse_cnt == 1, "R5 bus wake", pulse_cnt, 1);
        check(pulse_src == 1'b0, "R5 bus src", pulse_src, 0);
        check(pulse_cyc - start == BUS_LEN + 2, "R5 bus latency", pulse_cyc - start, BUS_LEN + 2);
        leave_sleep();
    endtask

    task automatic t_bus_short();
        enter_sleep(1'b1);
        bus_rx_i = 1'b0;
        idle(BUS_LEN - 1);
        bus_rx_i = 1'b1;
        idle(BUS_LEN + 6);
        check(pulse_cnt == 0, "R6 short bus ignored", pulse_cnt, 0);
        leave_sleep();
    endtask

    task automatic t_one_shot_rearm();
        int width;
        enter_sleep(1'b1);
        wake_pin_i = 1'b0;
        width = 0;
        for (int i = 0; i < PIN_LEN + 6; i++) begin
            @(negedge clk);
            if (wake_pulse_o) width++;
        end
        check(width == 1, "R7 pulse width", width, 1);
        bus_rx_i = 1'b0;
        wake_pin_i = 1'b1;
        idle(3 * PIN_LEN);
        wake_pin_i = 1'b0;
        idle(3 * PIN_LEN);
        bus_rx_i = 1'b1;
        check(pulse_cnt == 1, "R7 no repeat before re-arm", pulse_cnt, 1);
        leave_sleep();
        enter_sleep(1'b0);
        wake_pin_i = 1'b1;
        idle(PIN_LEN + 6);
        check(pulse_cnt == 1 && pulse_src == 1'b1, "R7 re-armed wake", pulse_cnt, 1);
        leave_sleep();
    endtask

    task automatic t_priority();
        bus_len_i = CNT_W'(PIN_LEN);
        enter_sleep(1'b1);
        wake_pin_i = 1'b0;
        bus_rx_i = 1'b0;
        idle(PIN_LEN + 6);
        bus_rx_i = 1'b1;
        check(pulse_cnt == 1, "R8 one pulse", pulse_cnt, 1);
        check(pulse_src == 1'b0, "R8 bus wins", pulse_src, 0);
        leave_sleep();
        bus_len_i = CNT_W'(BUS_LEN);
    endtask

    task automatic t_restart();
        enter_sleep(1'b0);
        wake_pin_i = 1'b1;
        idle(PIN_LEN - 2);
        wake_pin_i = 1'b0;
        idle(1);
        wake_pin_i = 1'b1;
        idle(PIN_LEN - 2);
        wake_pin_i = 1'b0;
        bus_rx_i = 1'b0;
        idle(BUS_LEN - 2);
        bus_rx_i = 1'b1;
        idle(1);
        bus_rx_i = 1'b0;
        idle(BUS_LEN - 2);
        bus_rx_i = 1'b1;
        idle(PIN_LEN + 6);
        check(pulse_cnt == 0, "R9 filters restart", pulse_cnt, 0);
        leave_sleep();
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_awake_quiet();
        t_pin_wake(1'b1, "R2 falling pin wake");
        t_pin_wake(1'b0, "R3 rising pin wake");
        t_pin_short();
        t_bus_wake();
        t_bus_short();
        t_one_shot_rearm();
        t_priority();
        t_restart();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule